// File: doc/BRIEF.md
# Serial ADC Sample Streamer

This block turns a 12-bit serial analog-to-digital converter into a steady stream of bytes for a host link. It reads the converter over a three-wire synchronous link (active-low select, serial clock, data from the converter). Each result is widened to a 16-bit word and handed byte by byte to a UART through a valid/ready byte port.

After reset the block stays quiet until it sees `start`. It then raises `run`, sends one zero byte so the receiver can find the byte boundaries, and loops forever: one conversion, then the two bytes of that result, then a wait until the loop period has elapsed. Only reset ends the loop.

The loop period counts cycles of the block's own clock, so the sample spacing has no jitter. The period is a base loop time. A non-zero pause setting of N ms adds N ms plus a fixed pause overhead on top of that base.

Top module: `adcs_streamer`

## Requirements
- R1: From reset until `start` is sampled high, `run` is 0, `adc_cs_n` is 1, `adc_sclk` is 0 and `tx_valid` is 0.
- R2: `start` sampled high while idle sets `run` to 1, and `run` stays 1 until reset. Later `start` pulses have no effect on the byte stream.
- R3: The first byte sent after `start` is 0x00. It is sent exactly once, before the first conversion begins.
- R4: A conversion drives `adc_cs_n` low with `adc_sclk` low and produces LEAD_CLKS+12 rising `adc_sclk` edges, each half period lasting HALF_CYC clocks. `adc_sdo` is captured on each rising edge. The captures at rising edges LEAD_CLKS+1 to LEAD_CLKS+12 form the result, most significant bit first. `adc_cs_n` returns high after the last falling edge, and `adc_sclk` stays low whenever `adc_cs_n` is high.
- R5: The result s is carried as the word {4'b0000, s}. Byte 0 (word bits 7:0) is sent first and byte 1 (word bits 15:8, upper nibble always zero) second.
- R6: Conversions and transfers strictly alternate. Each conversion is followed by exactly its two bytes before the next conversion starts, and no byte is offered while `adc_cs_n` is low.
- R7: A byte is transferred on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R8: When the transfers finish in time, successive `adc_cs_n` falling edges are exactly P clocks apart. P is BASE_CYC if the pause value is 0, and BASE_CYC + N*CYC_PER_MS + PAUSE_OVH_CYC if it is N != 0. The pause value used is the one present in the clock cycle before the earlier of the two falling edges.
- R9: If byte 1 is accepted after the period has already elapsed, the next `adc_cs_n` falling edge comes on the second clock edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing derives from it |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins streaming when sampled high while idle |
| pause_ms | input | PAUSE_W | Extra loop delay in ms; 0 selects the base period |
| run | output | 1 | Run indicator, high once streaming has begun |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| adc_sdo | input | 1 | Serial data from the converter |
| tx_valid | output | 1 | Byte on tx_data is offered to the UART |
| tx_data | output | 8 | Byte offered to the UART |
| tx_ready | input | 1 | UART accepts the byte on this edge when high |

## Verification
On every cycle the assertions check the following: the silence before `run`, the stickiness of `run`, `adc_sclk` resting low with the select released, no byte offered during a conversion, a stalled byte held steady, the zero upper nibble of byte 1, and the rule that a new conversion never starts before the period timer reports due. Other behaviour only the directed scenarios can show. That covers the exact bit order recovered from the serial line and the content of each byte, the single zero byte at the head of the stream, the cycle-exact spacing of conversions as the pause value changes, and the restart timing after a long stall on the UART side.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_KICK,
    ST_READ,
    ST_LO,
    ST_HI,
    ST_WAIT
  } st_e;

  localparam int unsigned SAMPLE_W = 12;
  localparam int unsigned WORD_W   = 16;

  // widen a converter result to the transmitted word, spare bits zero
  function automatic logic [WORD_W-1:0] pack_word(input logic [SAMPLE_W-1:0] s);
    return {4'b0000, s};
  endfunction

  // pick byte 0 (low half) or byte 1 (high half) of a word
  function automatic logic [7:0] word_byte(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  // loop period in clocks for a given pause setting
  function automatic logic [31:0] loop_cycles(input logic [31:0] base,
                                              input logic [31:0] per_ms,
                                              input logic [31:0] ovh,
                                              input logic [31:0] pause);
    if (pause == 32'd0) return base;
    return base + pause * per_ms + ovh;
  endfunction

endpackage

// File: rtl/adcs_spi_rd.sv
module adcs_spi_rd #(
  parameter int unsigned HALF_CYC  = 4,
  parameter int unsigned LEAD_CLKS = 2,
  parameter int unsigned DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  output logic                 cs_n,
  output logic                 sclk,
  input  logic                 sdo,
  output logic                 done,
  output logic [DATA_BITS-1:0] data
);

  localparam int unsigned NCLK  = LEAD_CLKS + DATA_BITS;
  localparam int unsigned NEDGE = 2 * NCLK;
  localparam int unsigned DW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned EW    = $clog2(NEDGE + 1);

  logic                 busy;
  logic [DW-1:0]        div;
  logic [EW-1:0]        edges;
  logic [DATA_BITS-1:0] shreg;

  // named internal events
  logic half_tick, rise_tick, fin_tick, keep_bit;

  assign half_tick = busy && (div == DW'(HALF_CYC - 1));
  assign fin_tick  = half_tick && (edges == EW'(NEDGE));
  assign rise_tick = half_tick && !fin_tick && !sclk;
  // edges is even before a rise; rises already done = edges/2
  assign keep_bit  = rise_tick && (edges >= EW'(2 * LEAD_CLKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      div   <= '0;
      edges <= '0;
      shreg <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy  <= 1'b1;
        cs_n  <= 1'b0;
        sclk  <= 1'b0;
        div   <= '0;
        edges <= '0;
      end else if (busy) begin
        if (half_tick) div <= '0;
        else           div <= div + 1'b1;
        if (fin_tick) begin
          busy <= 1'b0;
          cs_n <= 1'b1;
          done <= 1'b1;
        end else if (half_tick) begin
          sclk  <= ~sclk;
          edges <= edges + 1'b1;
        end
        if (keep_bit) shreg <= {shreg[DATA_BITS-2:0], sdo};
      end
    end
  end

  assign data = shreg;

  p_sclk_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_done_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  p_sclk_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_tick) |=> $stable(sclk));

  p_go_when_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

endmodule

// File: rtl/adcs_byte_port.sv
module adcs_byte_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       taken
);

  assign taken = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (taken) begin
      tx_valid <= 1'b0;
    end
  end

  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_load_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!tx_valid || tx_ready));

endmodule

// File: rtl/adcs_pacer.sv
module adcs_pacer
  import adcs_pkg::*;
#(
  parameter int unsigned BASE_CYC      = 186567,
  parameter int unsigned CYC_PER_MS    = 50000,
  parameter int unsigned PAUSE_OVH_CYC = 12000,
  parameter int unsigned PAUSE_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [PAUSE_W-1:0] pause_ms,
  output logic               due
);

  logic [31:0] cnt;
  logic [31:0] period;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      period <= 32'(BASE_CYC);
    end else if (restart) begin
      cnt    <= 32'd1;
      period <= loop_cycles(32'(BASE_CYC), 32'(CYC_PER_MS),
                            32'(PAUSE_OVH_CYC), 32'(pause_ms));
    end else if (cnt != '1) begin
      cnt <= cnt + 32'd1;
    end
  end

  // restart on the edge after due keeps restarts exactly period apart
  assign due = (cnt >= period - 32'd1);

  p_count_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && cnt != '1) |=> (cnt == $past(cnt) + 32'd1));

endmodule

// File: rtl/adcs_streamer.sv
module adcs_streamer
  import adcs_pkg::*;
#(
  parameter int unsigned HALF_CYC      = 4,
  parameter int unsigned LEAD_CLKS     = 2,
  parameter int unsigned BASE_CYC      = 186567,
  parameter int unsigned CYC_PER_MS    = 50000,
  parameter int unsigned PAUSE_OVH_CYC = 12000,
  parameter int unsigned PAUSE_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PAUSE_W-1:0] pause_ms,
  output logic               run,
  output logic               adc_cs_n,
  output logic               adc_sclk,
  input  logic               adc_sdo,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  input  logic               tx_ready
);

  st_e                 st, nxt;
  logic [WORD_W-1:0]   word_q;
  logic [SAMPLE_W-1:0] spi_data;

  // named internal events
  logic       kick, spi_done, taken, due, load;
  logic [7:0] ld_byte;

  assign kick = (st == ST_KICK);

  adcs_spi_rd #(
    .HALF_CYC (HALF_CYC),
    .LEAD_CLKS(LEAD_CLKS),
    .DATA_BITS(SAMPLE_W)
  ) u_rd (
    .clk (clk),
    .rst_n(rst_n),
    .go  (kick),
    .cs_n(adc_cs_n),
    .sclk(adc_sclk),
    .sdo (adc_sdo),
    .done(spi_done),
    .data(spi_data)
  );

  adcs_pacer #(
    .BASE_CYC     (BASE_CYC),
    .CYC_PER_MS   (CYC_PER_MS),
    .PAUSE_OVH_CYC(PAUSE_OVH_CYC),
    .PAUSE_W      (PAUSE_W)
  ) u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (kick),
    .pause_ms(pause_ms),
    .due     (due)
  );

  adcs_byte_port u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_byte(ld_byte),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .taken    (taken)
  );

  always_comb begin
    nxt     = st;
    load    = 1'b0;
    ld_byte = 8'h00;
    unique case (st)
      ST_IDLE: if (start) begin
        nxt  = ST_SYNC;
        load = 1'b1;
      end
      ST_SYNC: if (taken) nxt = ST_KICK;
      ST_KICK: nxt = ST_READ;
      ST_READ: if (spi_done) begin
        nxt     = ST_LO;
        load    = 1'b1;
        ld_byte = word_byte(pack_word(spi_data), 1'b0);
      end
      ST_LO: if (taken) begin
        nxt     = ST_HI;
        load    = 1'b1;
        ld_byte = word_byte(word_q, 1'b1);
      end
      ST_HI:   if (taken) nxt = ST_WAIT;
      ST_WAIT: if (due) nxt = ST_KICK;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      run    <= 1'b0;
      word_q <= '0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && start) run <= 1'b1;
      if (spi_done) word_q <= pack_word(spi_data);
    end
  end

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (adc_cs_n && !tx_valid));

  p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);

  p_no_byte_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !tx_valid);

  p_top_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HI && tx_valid) |-> (tx_data[7:4] == 4'h0));

  p_kick_when_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !due) |=> !kick);

endmodule

// File: tb/sim_adcs_streamer.sv
module sim_adcs_streamer;

  localparam int HALF  = 2;
  localparam int LEAD  = 2;
  localparam int BASE  = 400;
  localparam int CPM   = 100;
  localparam int OVH   = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] pause_ms = 8'd0;
  logic       run, adc_cs_n, adc_sclk, adc_sdo, tx_valid, tx_ready;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  adcs_streamer #(
    .HALF_CYC(HALF), .LEAD_CLKS(LEAD), .BASE_CYC(BASE),
    .CYC_PER_MS(CPM), .PAUSE_OVH_CYC(OVH), .PAUSE_W(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pause_ms(pause_ms), .run(run),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  function automatic int sv(input int i);
    case (i)
      0: return 'hABC; 1: return 'hFFF; 2: return 'h000; 3: return 'h5A5;
      4: return 'h800; 5: return 'h001; 6: return 'h7FE; 7: return 'h3C3;
      default: return 'h2D7;
    endcase
  endfunction

  function automatic int period_of(input int p);
    if (p == 0) return BASE;
    return BASE + p * CPM + OVH;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and stream monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  rise_cnt = 0;
  int  cur_val = 0;
  int  nrd = 0;
  int  bad_clk = 0;
  int  ev_n = 0;
  int  ev_kind [0:63];
  int  ev_val  [0:63];
  int  fall_cyc[0:15];
  int  acc_gap [0:15];
  int  nfall = 0;
  int  last_acc = 0;
  bit  prev_cs = 1'b1;
  bit  prev_sclk = 1'b0;

  function automatic bit sdo_bit(input int cnt, input int v);
    if (cnt >= LEAD && cnt < LEAD + 12) return v[11 - (cnt - LEAD)];
    return 1'b0;
  endfunction

  assign adc_sdo = sdo_bit(rise_cnt, cur_val);

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (ev_n < 64) begin ev_kind[ev_n] = 1; ev_val[ev_n] = int'(tx_data); end
        ev_n++;
        last_acc = cyc;
      end
      if (prev_cs && !adc_cs_n) begin
        if (ev_n < 64) begin ev_kind[ev_n] = 0; ev_val[ev_n] = 0; end
        ev_n++;
        if (nfall < 16) begin fall_cyc[nfall] = cyc; acc_gap[nfall] = cyc - last_acc; end
        nfall++;
        rise_cnt = 0;
        cur_val = sv(nrd);
        nrd++;
      end else if (!adc_cs_n && !prev_sclk && adc_sclk) begin
        rise_cnt++;
      end
      if (!prev_cs && adc_cs_n && rise_cnt != LEAD + 12) bad_clk++;
      prev_cs = adc_cs_n;
      prev_sclk = adc_sclk;
    end
  end

  task automatic drive_step();
    @(posedge clk); #1;
  endtask

  task automatic wait_falls(input int n);
    while (nfall < n) @(posedge clk);
  endtask

  task automatic t_idle();
    bit b_run = 0, b_cs = 0, b_sclk = 0, b_val = 0;
    tx_ready = 1'b1;
    rst_n = 1'b0;
    repeat (5) drive_step();
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (run) b_run = 1;
      if (!adc_cs_n) b_cs = 1;
      if (adc_sclk) b_sclk = 1;
      if (tx_valid) b_val = 1;
    end
    chk(!b_run, "R1 run before start", b_run, 0);
    chk(!b_cs, "R1 cs_n before start", b_cs, 0);
    chk(!b_sclk, "R1 sclk before start", b_sclk, 0);
    chk(!b_val, "R1 tx_valid before start", b_val, 0);
  endtask

  task automatic t_launch();
    drive_step();
    start = 1'b1;
    drive_step();
    start = 1'b0;
    while (ev_n < 1) @(negedge clk);
    chk(ev_kind[0] == 1 && ev_val[0] == 0, "R3 first event is zero byte", ev_val[0], 0);
    chk(run == 1'b1, "R2 run raised", run, 1);
    // a second start while running must change nothing
    drive_step();
    start = 1'b1;
    drive_step();
    start = 1'b0;
  endtask

  task automatic t_pacing();
    wait_falls(2);
    drive_step();
    pause_ms = 8'd3;
    wait_falls(4);
    drive_step();
    pause_ms = 8'd1;
    wait_falls(6);
    chk(fall_cyc[1] - fall_cyc[0] == period_of(0), "R8 spacing pause 0 a",
        fall_cyc[1] - fall_cyc[0], period_of(0));
    chk(fall_cyc[2] - fall_cyc[1] == period_of(0), "R8 spacing pause 0 b",
        fall_cyc[2] - fall_cyc[1], period_of(0));
    chk(fall_cyc[3] - fall_cyc[2] == period_of(3), "R8 spacing pause 3 a",
        fall_cyc[3] - fall_cyc[2], period_of(3));
    chk(fall_cyc[4] - fall_cyc[3] == period_of(3), "R8 spacing pause 3 b",
        fall_cyc[4] - fall_cyc[3], period_of(3));
    chk(fall_cyc[5] - fall_cyc[4] == period_of(1), "R8 spacing pause 1",
        fall_cyc[5] - fall_cyc[4], period_of(1));
  endtask

  task automatic t_stall();
    logic [7:0] held;
    bit moved = 0;
    drive_step();
    tx_ready = 1'b0;
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    held = tx_data;
    chk(held == 8'(sv(5) & 'hFF), "R5 stalled byte 0 value", held, sv(5) & 'hFF);
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      if (!tx_valid || tx_data != held) moved = 1;
    end
    chk(!moved, "R7 byte held while ready low", moved, 0);
    drive_step();
    tx_ready = 1'b1;
    wait_falls(8);
    chk(acc_gap[6] == 3, "R9 restart after late byte", acc_gap[6], 3);
    chk(fall_cyc[7] - fall_cyc[6] == period_of(1), "R8 spacing after stall",
        fall_cyc[7] - fall_cyc[6], period_of(1));
  endtask

  task automatic t_sequence();
    int zeros_at_head = 0;
    chk(bad_clk == 0, "R4 rising clocks per conversion", bad_clk, 0);
    for (int r = 0; r < 7; r++) begin
      int b = 1 + 3 * r;
      chk(ev_kind[b] == 0 && ev_kind[b+1] == 1 && ev_kind[b+2] == 1,
          "R6 read then two bytes", ev_kind[b] * 100 + ev_kind[b+1] * 10 + ev_kind[b+2], 11);
      chk(ev_val[b+1] == (sv(r) & 'hFF) && ev_val[b+2] == (sv(r) >> 8),
          "R5 R4 byte order and bits", ev_val[b+1] * 256 + ev_val[b+2],
          (sv(r) & 'hFF) * 256 + (sv(r) >> 8));
    end
    for (int i = 0; i < 22; i++)
      if (ev_kind[i] == 1 && ev_val[i] == 0 && (i == 0 || ev_kind[i-1] == 1) && i % 3 != 0)
        zeros_at_head++;
    chk(ev_kind[1] == 0, "R3 zero byte sent once before first read", ev_kind[1], 0);
    chk(run == 1'b1, "R2 run still high", run, 1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", nfall, 8);
    finish_run();
  end

  initial begin
    t_idle();
    t_launch();
    t_pacing();
    t_stall();
    t_sequence();
    finish_run();
  end

endmodule